// File: doc/BRIEF.md
# Bidirectional Timer Counter with Compare

The block is an 8-bit timer/counter. It advances by one on each tick from a selected tick source. The counting sequence depends on the wave mode. In the two up-only modes the counter wraps from its ceiling back to zero. In the two swing modes it climbs to the ceiling, turns round and descends to zero. The ceiling is either the fixed maximum 0xFF or the active value of compare channel A, depending on the mode.

Two compare channels, A and B, each hold a staging register and an active register. The active value is compared against the counter on every tick. A tick taken while the counter equals a channel's active value sets that channel's sticky flag. Another sticky flag records wrap and bottom-turn events. Software clears any flag by writing one to its bit.

Direction is held by a two-state machine with the states RISE and FALL. It has four transitions:
- RISE to FALL, on a tick at the ceiling in a swing mode.
- FALL to RISE, on a tick at zero in a swing mode.
- FALL to RISE, whenever a non-swing mode is selected.
- Otherwise, the state is held.

Top module: `bidir_timer`

## Requirements
- R1: After reset the counter is 0x00, all three flags are 0 and `dir_down` is 0 (RISE). Both active compare values reset to 0xFF.
- R2: With `clk_sel` = 2'b00 or 2'b11 no tick is taken and the counter holds its value, whatever `ext_tick` does.
- R3: `clk_sel` = 2'b01 gives a tick on every clock cycle. `clk_sel` = 2'b10 gives a tick only in cycles where `ext_tick` is 1.
- R4: In modes 2'b00 (plain) and 2'b01 (wrap at A), a tick with the counter at the ceiling loads 0x00 and sets flag bit 0 (the overflow flag). Other ticks add one.
- R5: Flags are sticky. Writing 1 to a `flag_clr` bit clears the matching flag, but a set event in the same cycle wins over the clear.
- R6: A counter write (`cnt_we`) loads `cnt_wdata` regardless of a tick in the same cycle. That cycle also produces no compare hit, no overflow and no direction change.
- R7: A tick taken while the counter equals channel A's active value sets flag bit 1. The same event on channel B sets flag bit 2. Each channel sets only its own bit.
- R8: In mode 2'b00, a write to a compare channel (`cmp_we` bit 0 = A, bit 1 = B, data `cmp_wdata`) updates both its staging and active values at once.
- R9: In modes 2'b01, 2'b10 and 2'b11, a compare write goes only to the staging register. The active value takes the staged value on a RISE-state tick at the ceiling.
- R10: In modes 2'b01 and 2'b11 the ceiling is channel A's active value. In modes 2'b00 and 2'b10 it is 0xFF.
- R11: In swing modes 2'b10 and 2'b11, a tick at the ceiling in RISE subtracts one and enters FALL (`dir_down` = 1) without setting the overflow flag.
- R12: In swing modes, a tick at 0x00 in FALL loads 0x01, enters RISE and sets the overflow flag.
- R13: When a non-swing mode is selected while in FALL, the state returns to RISE on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Tick source: 00/11 stop, 01 every cycle, 10 external tick |
| ext_tick | input | 1 | External tick enable, one clock cycle wide |
| mode | input | 2 | Wave mode: 00 plain, 01 wrap at A, 10 swing to 0xFF, 11 swing to A |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cmp_we | input | 2 | Compare write strobes, bit 0 channel A, bit 1 channel B |
| cmp_wdata | input | 8 | Compare write data |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 overflow, bit 1 A, bit 2 B |
| count | output | 8 | Current counter value |
| flags | output | 3 | Sticky flags: bit 0 overflow, bit 1 A, bit 2 B |
| dir_down | output | 1 | 1 while the direction state is FALL |

## Verification
The counter, flags, direction state and active compare values are all registers, so every stimulus shows at the ports exactly one rising edge after it is applied. That includes a tick, a counter write, a compare write and a flag clear. A compare write in a buffered mode first shows as a change of ceiling or hit position only after the next ceiling tick. The driver applies each stimulus just after a falling edge and queues its expected outputs, tagged with the cycle index of the following edge. The monitor pops and compares each entry at the falling edge after that edge, half a period away from any update.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN     = 2'b00,
        MODE_WRAP_A    = 2'b01,
        MODE_SWING_MAX = 2'b10,
        MODE_SWING_A   = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } tmr_dir_e;

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
    input  logic [1:0] sel_i,
    input  logic       ext_i,
    output logic       tick_o
);

    always_comb begin
        unique case (sel_i)
            2'b01:   tick_o = 1'b1;
            2'b10:   tick_o = ext_i;
            default: tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         imm_i,
    input  logic         load_i,
    input  logic         adv_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] act_o,
    output logic         hit_o
);

    localparam logic [W-1:0] RST_VAL = '1;

    logic [W-1:0] stage_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= RST_VAL;
            act_q   <= RST_VAL;
        end else begin
            if (we_i) begin
                stage_q <= wdata_i;
            end
            if (imm_i && we_i) begin
                act_q <= wdata_i;
            end else if (!imm_i && load_i) begin
                act_q <= stage_q;
            end
        end
    end

    assign act_o = act_q;
    assign hit_o = adv_i && (cnt_i == act_q);

    // R9: active value frozen outside the ceiling event in buffered modes
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_i && !load_i) |=> $stable(act_q));

    // R8: direct update in plain mode
    a_r8_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_i && we_i) |=> (act_q == $past(wdata_i)));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  tmr_mode_e    mode_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] ceil_a_i,
    output logic [W-1:0] cnt_o,
    output logic         fall_o,
    output logic         adv_o,
    output logic         load_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] MAXV = '1;

    tmr_dir_e     st_q, st_n;
    logic [W-1:0] cnt_q, cnt_n;
    logic         swing, adv, at_top;
    logic [W-1:0] ceil_v;

    assign swing  = (mode_i == MODE_SWING_MAX) || (mode_i == MODE_SWING_A);
    assign ceil_v = ((mode_i == MODE_WRAP_A) || (mode_i == MODE_SWING_A)) ? ceil_a_i : MAXV;
    assign adv    = tick_i && !wr_i;
    assign at_top = (cnt_q == ceil_v);

    // direction state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RISE;
        else        st_q <= st_n;
    end

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_RISE: if (swing && adv && at_top) st_n = ST_FALL;
            ST_FALL: begin
                if (!swing)                       st_n = ST_RISE;
                else if (adv && (cnt_q == ZERO))  st_n = ST_RISE;
            end
        endcase
    end

    // counter datapath and event outputs
    always_comb begin
        cnt_n = cnt_q;
        ovf_o = 1'b0;
        if (wr_i) begin
            cnt_n = wdata_i;
        end else if (adv) begin
            unique case (st_q)
                ST_RISE: begin
                    if (at_top) begin
                        if (swing) begin
                            cnt_n = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
                        end else begin
                            cnt_n = ZERO;
                            ovf_o = 1'b1;
                        end
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                ST_FALL: begin
                    if (cnt_q == ZERO) begin
                        cnt_n = ONE;
                        ovf_o = 1'b1;
                    end else begin
                        cnt_n = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_n;
    end

    assign cnt_o  = cnt_q;
    assign fall_o = (st_q == ST_FALL);
    assign adv_o  = adv;
    assign load_o = adv && (st_q == ST_RISE) && at_top;

    // R2: no tick and no write leaves the counter untouched
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_i) |=> $stable(cnt_q));

    // R6: a counter write always lands
    a_r6_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_q == $past(wdata_i)));

    // R12: bottom turn in swing modes
    a_r12_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (swing && adv && (st_q == ST_FALL) && (cnt_q == ZERO))
            |=> ((cnt_q == ONE) && (st_q == ST_RISE)));

    // R13: non-swing mode forces RISE
    a_r13_leave: assert property (@(posedge clk) disable iff (!rst_n)
        !swing |=> (st_q == ST_RISE));

endmodule

// File: rtl/bidir_timer.sv
module bidir_timer
    import tmr_pkg::*;
#(
    parameter int W   = 8,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     clk_sel,
    input  logic           ext_tick,
    input  logic [1:0]     mode,
    input  logic           cnt_we,
    input  logic [W-1:0]   cnt_wdata,
    input  logic [NCH-1:0] cmp_we,
    input  logic [W-1:0]   cmp_wdata,
    input  logic [NCH:0]   flag_clr,
    output logic [W-1:0]   count,
    output logic [NCH:0]   flags,
    output logic           dir_down
);

    tmr_mode_e               mode_e;
    logic                    tick, adv, load_evt, ovf_evt, imm;
    logic [W-1:0]            cnt;
    logic [NCH-1:0][W-1:0]   act;
    logic [NCH-1:0]          hit;
    logic [NCH:0]            set_v;
    logic [NCH:0]            flag_q;

    assign mode_e = tmr_mode_e'(mode);
    assign imm    = (mode_e == MODE_PLAIN);

    tmr_tick_sel u_tick (
        .sel_i  (clk_sel),
        .ext_i  (ext_tick),
        .tick_o (tick)
    );

    tmr_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .mode_i   (mode_e),
        .wr_i     (cnt_we),
        .wdata_i  (cnt_wdata),
        .ceil_a_i (act[0]),
        .cnt_o    (cnt),
        .fall_o   (dir_down),
        .adv_o    (adv),
        .load_o   (load_evt),
        .ovf_o    (ovf_evt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tmr_cmp_chan #(.W(W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (cmp_we[c]),
            .wdata_i (cmp_wdata),
            .imm_i   (imm),
            .load_i  (load_evt),
            .adv_i   (adv),
            .cnt_i   (cnt),
            .act_o   (act[c]),
            .hit_o   (hit[c])
        );
    end

    assign set_v = {hit, ovf_evt};

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | set_v;
    end

    assign count = cnt;
    assign flags = flag_q;

    for (genvar f = 0; f <= NCH; f++) begin : g_flag_chk
        // R5: clear takes effect when no set event competes
        a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[f] && !set_v[f]) |=> !flag_q[f]);
        // R7 / R4: an event always leaves its flag set
        a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[f] |=> flag_q[f]);
    end

endmodule

// File: tb/bidir_timer_test.sv
module bidir_timer_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       ext_tick = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = 8'h00;
    logic [1:0] cmp_we = 2'b00;
    logic [7:0] cmp_wdata = 8'h00;
    logic [2:0] flag_clr = 3'b000;
    logic [7:0] count;
    logic [2:0] flags;
    logic       dir_down;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_timer uut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_tick(ext_tick),
        .mode(mode), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .flag_clr(flag_clr), .count(count),
        .flags(flags), .dir_down(dir_down)
    );

    typedef struct {
        int         due;
        logic [7:0] c;
        logic [2:0] f;
        logic       d;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(input exp_t e);
        checks++;
        if (count !== e.c || flags !== e.f || dir_down !== e.d) begin
            errors++;
            $display("FAIL %s: got cnt=%h flags=%b dn=%b expected cnt=%h flags=%b dn=%b",
                     e.tag, count, flags, dir_down, e.c, e.f, e.d);
        end
    endtask

    // monitor: pops each expectation at the falling edge after its edge
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            e = sb.pop_front();
            compare(e);
        end
    end

    // driver: inputs already set; queue expectation, wait one cycle, drop pulses
    task automatic step(input logic [7:0] c, input logic [2:0] f,
                        input logic d, input string tag);
        exp_t e;
        e.due = cyc + 1; e.c = c; e.f = f; e.d = d; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        cnt_we = 1'b0; cmp_we = 2'b00; flag_clr = 3'b000; ext_tick = 1'b0;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        exp_t r;
        repeat (2) @(posedge clk);
        @(negedge clk);
        r.due = 0; r.c = 8'h00; r.f = 3'b000; r.d = 1'b0; r.tag = "R1 reset state";
        compare(r);
        rst_n = 1'b1;

        // plain mode: load both compare channels directly
        cmp_we = 2'b11; cmp_wdata = 8'h80; step(8'h00, 3'b000, 0, "R8 load both");

        // R2: stopped sources
        step(8'h00, 3'b000, 0, "R2 sel 00");
        ext_tick = 1'b1; step(8'h00, 3'b000, 0, "R2 sel 00 ext high");
        clk_sel = 2'b11; ext_tick = 1'b1; step(8'h00, 3'b000, 0, "R2 sel 11");

        // R3: tick sources
        clk_sel = 2'b01;
        step(8'h01, 3'b000, 0, "R3 sys tick 1");
        step(8'h02, 3'b000, 0, "R3 sys tick 2");
        step(8'h03, 3'b000, 0, "R3 sys tick 3");
        clk_sel = 2'b10;
        step(8'h03, 3'b000, 0, "R3 ext low");
        ext_tick = 1'b1; step(8'h04, 3'b000, 0, "R3 ext high");
        step(8'h04, 3'b000, 0, "R3 ext low again");

        // R4 wrap at 0xFF
        clk_sel = 2'b00; cnt_we = 1'b1; cnt_wdata = 8'hFE;
        step(8'hFE, 3'b000, 0, "R6 counter write");
        clk_sel = 2'b01;
        step(8'hFF, 3'b000, 0, "R4 up to max");
        step(8'h00, 3'b001, 0, "R4 wrap sets overflow");

        // R5 clear and set priority
        clk_sel = 2'b00; flag_clr = 3'b001;
        step(8'h00, 3'b000, 0, "R5 clear overflow");
        cnt_we = 1'b1; cnt_wdata = 8'hFF;
        step(8'hFF, 3'b000, 0, "R6 write ff");
        clk_sel = 2'b01; flag_clr = 3'b001;
        step(8'h00, 3'b001, 0, "R5 set beats clear");
        clk_sel = 2'b00; flag_clr = 3'b001;
        step(8'h00, 3'b000, 0, "R5 clear again");

        // R6 / R7 / R8
        cmp_we = 2'b01; cmp_wdata = 8'h05;
        step(8'h00, 3'b000, 0, "R8 A direct");
        clk_sel = 2'b01; cnt_we = 1'b1; cnt_wdata = 8'h05;
        step(8'h05, 3'b000, 0, "R6 write over tick");
        cnt_we = 1'b1; cnt_wdata = 8'h09;
        step(8'h09, 3'b000, 0, "R6 write blocks match");
        cnt_we = 1'b1; cnt_wdata = 8'h05;
        step(8'h05, 3'b000, 0, "R6 write back");
        step(8'h06, 3'b010, 0, "R7 A hit");
        cmp_we = 2'b10; cmp_wdata = 8'h07;
        step(8'h07, 3'b010, 0, "R8 B direct");
        step(8'h08, 3'b110, 0, "R7 B hit");
        clk_sel = 2'b00; flag_clr = 3'b110; cmp_we = 2'b10; cmp_wdata = 8'h80;
        step(8'h08, 3'b000, 0, "R5 clear hits");

        // R9 / R10 wrap at A with buffered update
        mode = 2'b01; cnt_we = 1'b1; cnt_wdata = 8'h00;
        step(8'h00, 3'b000, 0, "R10 mode wrap A");
        cmp_we = 2'b01; cmp_wdata = 8'h09;
        step(8'h00, 3'b000, 0, "R9 staged write");
        clk_sel = 2'b01;
        for (int i = 1; i <= 5; i++) step(8'(i), 3'b000, 0, "R9 count to old ceiling");
        step(8'h00, 3'b011, 0, "R10 wrap at old A");
        flag_clr = 3'b011;
        step(8'h01, 3'b000, 0, "R9 new value after ceiling");
        for (int i = 2; i <= 9; i++) step(8'(i), 3'b000, 0, "R9 count to new ceiling");
        step(8'h00, 3'b011, 0, "R9 wrap at new A");

        // R11 / R12 swing to 0xFF
        clk_sel = 2'b00; mode = 2'b10; flag_clr = 3'b011; cnt_we = 1'b1; cnt_wdata = 8'hFE;
        step(8'hFE, 3'b000, 0, "R11 setup");
        clk_sel = 2'b01;
        step(8'hFF, 3'b000, 0, "R11 reach max");
        step(8'hFE, 3'b000, 1, "R11 reverse at ceiling");
        clk_sel = 2'b00; cnt_we = 1'b1; cnt_wdata = 8'h01;
        step(8'h01, 3'b000, 1, "R6 write keeps direction");
        clk_sel = 2'b01;
        step(8'h00, 3'b000, 1, "R12 reach bottom");
        step(8'h01, 3'b001, 0, "R12 bottom turn overflow");

        // R10 swing to A, then R13
        clk_sel = 2'b00; mode = 2'b11; flag_clr = 3'b001; cnt_we = 1'b1; cnt_wdata = 8'h08;
        step(8'h08, 3'b000, 0, "R10 swing A setup");
        clk_sel = 2'b01;
        step(8'h09, 3'b000, 0, "R10 reach A");
        step(8'h08, 3'b010, 1, "R10 reverse at A with hit");
        clk_sel = 2'b00; mode = 2'b00;
        step(8'h08, 3'b010, 0, "R13 back to rise");

        wait (sb.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule